// File: doc/BRIEF.md
# Three-Wire Configuration Register Slave

This block lets a host program and read back a bank of eleven 32-bit configuration registers over one bidirectional serial data wire, a serial clock and an active-low chip select. The data wire is split at the block edge into an input, an output and an output enable, so a pad cell outside the block provides the tristate. Every register value is presented in parallel on a flat output bus for the logic it configures. After reset each register holds a fixed default.

Each transaction lasts 48 serial clock pulses. The first 12 bits form the header: eight leading zero bits, then a 4-bit register index. Bit 13 is a direction flag. Three turnaround bits of no meaning follow. The last 32 bits are register data, most significant bit first. Both sides sample on the rising edge of the serial clock and change data on the falling edge, and the serial clock rests low. The block runs on its own system clock. It resynchronises the three serial pins and works from the edges it detects.

A state machine tracks the frame. The states are ST_IDLE (chip select released), ST_ADDR (header bits), ST_RW (direction bit), ST_TURN (turnaround bits), ST_DATA (data bits) and ST_DONE (frame complete, further clocks ignored). The transitions are:
- ST_IDLE to ST_ADDR when chip select is asserted.
- ST_ADDR to ST_RW on the 12th rising edge.
- ST_RW to ST_TURN on the 13th rising edge.
- ST_TURN to ST_DATA on the 16th rising edge.
- ST_DATA to ST_DONE on the 48th rising edge.
- Any state to ST_IDLE whenever chip select is released.

Top module: `spi3_cfg_slave`

## Requirements
- R1: After reset the registers hold these defaults, by index: 0:0xBEA41603, 1:0x20550288, 2:0x0EAFA1DC, 3:0x698C0008, 4:0x00C00080, 5:0x08000070, 6:0x08000000, 7:0x010061B2, 8:0x01E0F401, 9:0x00C00002, 10:0x010061B0. Register i occupies bits [32*i+31 : 32*i] of `cfg_regs`.
- R2: A frame is sent MSB first and carries, in order: 8 zero bits, a 4-bit index, a direction bit (0 = write), 3 don't-care bits and 32 data bits. When the direction bit is 0, the 32 data bits replace the indexed register once the 48th rising edge has been taken.
- R3: When the direction bit is 1, the block drives the indexed register value MSB first. It raises `sdio_oe` and presents the MSB after the falling edge that follows the 16th rising edge. It shifts to the next bit on each later falling edge. It releases the line after the falling edge that follows the 48th rising edge.
- R4: `sdio_oe` stays low during the header, direction and turnaround bits of every frame, and throughout every write frame.
- R5: While `cs_n` is high, serial clock and data activity changes no register, and `sdio_oe` stays low.
- R6: If `cs_n` rises before the 48th rising edge, the registers are left unchanged. The next frame counts its bits from the first bit.
- R7: A frame with an index above 10 or a nonzero leading byte writes nothing. A read of such a frame drives 32 zero bits.
- R8: A write changes only the register it addresses.
- R9: Serial clock pulses after the 48th, with `cs_n` still low, are ignored: no further write takes place and the line is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, rests low |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data line as seen from the pad |
| sdio_o | output | 1 | Serial data driven towards the pad |
| sdio_oe | output | 1 | High while the block drives the data line |
| cfg_regs | output | 352 | All registers side by side, index 0 in the low bits |

## Verification
The hardest conditions to reach from the ports are a frame broken off at a phase boundary and the same frame running past its 48th bit. In either case a mistake in the bit counter shows up only as a missing or misplaced write in a later frame. The host model in the bench therefore takes a clock count as a parameter. It cuts write frames short just after the header, just after the direction bit, at the end of the turnaround and one bit before the end. Each cut is followed at once by a full write to the same register, which passes only if counting started again at bit one. The same model runs frames past 48 clocks with ones on the line, and it compares `sdio_oe` with the expected drive window on every rising edge.

// File: rtl/spi3_cfg_pkg.sv
package spi3_cfg_pkg;

    localparam int unsigned CFG_REG_W   = 32;
    localparam int unsigned CFG_REG_CNT = 11;
    localparam int unsigned HDR_PAD_W   = 8;
    localparam int unsigned HDR_IDX_W   = 4;
    localparam int unsigned HDR_TURN_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RW,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } frame_state_e;

    // Power-up contents of each register, by index.
    function automatic logic [CFG_REG_W-1:0] reg_default(input int unsigned idx);
        logic [31:0] v;
        case (idx)
            0:       v = 32'hBEA41603;
            1:       v = 32'h20550288;
            2:       v = 32'h0EAFA1DC;
            3:       v = 32'h698C0008;
            4:       v = 32'h00C00080;
            5:       v = 32'h08000070;
            6:       v = 32'h08000000;
            7:       v = 32'h010061B2;
            8:       v = 32'h01E0F401;
            9:       v = 32'h00C00002;
            10:      v = 32'h010061B0;
            default: v = 32'h0;
        endcase
        return CFG_REG_W'(v);
    endfunction

endpackage

// File: rtl/spi3_pin_sync.sv
module spi3_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic sdi_s
);

    logic [STAGES-1:0] sclk_sr;
    logic [STAGES-1:0] cs_sr;
    logic [STAGES-1:0] sdi_sr;
    logic              sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sr   <= '0;
            cs_sr     <= '1;
            sdi_sr    <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_sr   <= {sclk_sr[STAGES-2:0], sclk};
            cs_sr     <= {cs_sr[STAGES-2:0], cs_n};
            sdi_sr    <= {sdi_sr[STAGES-2:0], sdi};
            sclk_prev <= sclk_sr[STAGES-1];
        end
    end

    assign sclk_rise = sclk_sr[STAGES-1] & ~sclk_prev;
    assign sclk_fall = ~sclk_sr[STAGES-1] & sclk_prev;
    assign cs_act    = ~cs_sr[STAGES-1];
    assign sdi_s     = sdi_sr[STAGES-1];

endmodule

// File: rtl/spi3_reg_bank.sv
module spi3_reg_bank
    import spi3_cfg_pkg::*;
#(
    parameter int unsigned DATA_W   = CFG_REG_W,
    parameter int unsigned NUM_REGS = CFG_REG_CNT,
    parameter int unsigned ADR_W    = HDR_IDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);

    localparam logic [ADR_W:0] REG_LIMIT = (ADR_W+1)'(NUM_REGS);

    logic [DATA_W-1:0] q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= reg_default(i);
            end else if (wr_en && wr_addr == ADR_W'(i)) begin
                q[i] <= wr_data;
            end
        end
        assign regs_flat[i*DATA_W +: DATA_W] = q[i];

        // R6
        reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADR_W'(i)) |=> $stable(q[i]));
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADR_W'(i)) rd_data = q[i];
        end
    end

    // R7
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < REG_LIMIT));

endmodule

// File: rtl/spi3_frame_fsm.sv
module spi3_frame_fsm
    import spi3_cfg_pkg::*;
#(
    parameter int unsigned PAD_W    = HDR_PAD_W,
    parameter int unsigned ADR_W    = HDR_IDX_W,
    parameter int unsigned TURN_W   = HDR_TURN_W,
    parameter int unsigned DATA_W   = CFG_REG_W,
    parameter int unsigned NUM_REGS = CFG_REG_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADR_W-1:0]  rd_addr,
    output logic              wr_en,
    output logic [ADR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int unsigned HDR_W   = PAD_W + ADR_W;
    localparam int unsigned FRAME_W = HDR_W + 1 + TURN_W + DATA_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_TURN = CNT_W'(HDR_W + TURN_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_W - 1);
    localparam logic [ADR_W:0]   REG_LIMIT = (ADR_W+1)'(NUM_REGS);

    frame_state_e      state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-1:0]  hdr_sr;
    logic              rw_q;
    logic [DATA_W-1:0] din_sr;
    logic [DATA_W-1:0] dout_sr;
    logic              oe_q;
    logic              sdo_q;
    logic              wr_en_q;
    logic              hit;
    logic              in_frame;

    assign rd_addr  = hdr_sr[ADR_W-1:0];
    assign hit      = (hdr_sr[HDR_W-1 -: PAD_W] == '0) &&
                      ({1'b0, hdr_sr[ADR_W-1:0]} < REG_LIMIT);
    assign in_frame = (state == ST_ADDR) || (state == ST_RW) ||
                      (state == ST_TURN) || (state == ST_DATA);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cs_act) state_nx = ST_ADDR;
            ST_ADDR: if (sclk_rise && cnt == LAST_HDR) state_nx = ST_RW;
            ST_RW:   if (sclk_rise) state_nx = ST_TURN;
            ST_TURN: if (sclk_rise && cnt == LAST_TURN) state_nx = ST_DATA;
            ST_DATA: if (sclk_rise && cnt == LAST_BIT) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_DONE;
        endcase
        if (!cs_act) state_nx = ST_IDLE;
    end

    // Outputs and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            hdr_sr  <= '0;
            rw_q    <= 1'b0;
            din_sr  <= '0;
            dout_sr <= '0;
            oe_q    <= 1'b0;
            sdo_q   <= 1'b0;
            wr_en_q <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            if (!cs_act) begin
                cnt  <= '0;
                oe_q <= 1'b0;
            end else begin
                if (sclk_rise && in_frame) cnt <= cnt + 1'b1;
                if (sclk_rise && state == ST_ADDR) hdr_sr <= {hdr_sr[HDR_W-2:0], sdi};
                if (sclk_rise && state == ST_RW) rw_q <= sdi;
                if (sclk_rise && state == ST_TURN && cnt == LAST_TURN)
                    dout_sr <= (rw_q && hit) ? rd_data : '0;
                if (sclk_rise && state == ST_DATA) begin
                    din_sr <= {din_sr[DATA_W-2:0], sdi};
                    if (cnt == LAST_BIT && !rw_q && hit) wr_en_q <= 1'b1;
                end
                if (sclk_fall) begin
                    if (state == ST_DATA && rw_q) begin
                        oe_q    <= 1'b1;
                        sdo_q   <= dout_sr[DATA_W-1];
                        dout_sr <= {dout_sr[DATA_W-2:0], 1'b0};
                    end else begin
                        oe_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_addr = hdr_sr[ADR_W-1:0];
    assign wr_data = din_sr;
    assign sdo     = sdo_q;
    assign sdo_oe  = oe_q;

    // R4
    oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> rw_q);

    // R3
    oe_start_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> (state == ST_DATA));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !oe_q);

    // R2
    commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> (state == ST_DONE));

    // R9
    done_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) == ST_DONE && !sclk_fall) |=> $stable(oe_q));

endmodule

// File: rtl/spi3_cfg_slave.sv
module spi3_cfg_slave
    import spi3_cfg_pkg::*;
#(
    parameter int unsigned DATA_W      = CFG_REG_W,
    parameter int unsigned NUM_REGS    = CFG_REG_CNT,
    parameter int unsigned PAD_W       = HDR_PAD_W,
    parameter int unsigned ADR_W       = HDR_IDX_W,
    parameter int unsigned TURN_W      = HDR_TURN_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       cs_n,
    input  logic                       sdio_i,
    output logic                       sdio_o,
    output logic                       sdio_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);

    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_act;
    logic              sdi_s;
    logic [ADR_W-1:0]  rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADR_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;

    spi3_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdio_i),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .sdi_s     (sdi_s)
    );

    spi3_frame_fsm #(
        .PAD_W    (PAD_W),
        .ADR_W    (ADR_W),
        .TURN_W   (TURN_W),
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .sdi       (sdi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sdo       (sdio_o),
        .sdo_oe    (sdio_oe)
    );

    spi3_reg_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .ADR_W    (ADR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

endmodule

// File: tb/sim_spi3_cfg_slave.sv
module sim_spi3_cfg_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NREG       = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sclk = 1'b0;
    logic            cs_n = 1'b1;
    logic            sdio_i = 1'b0;
    logic            sdio_o;
    logic            sdio_oe;
    logic [NREG*32-1:0] cfg_flat;

    int tests = 0;
    int fails = 0;
    logic [31:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi3_cfg_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sdio_i   (sdio_i),
        .sdio_o   (sdio_o),
        .sdio_oe  (sdio_oe),
        .cfg_regs (cfg_flat)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        int bad = -1;
        for (int a = 0; a < NREG; a++)
            if (bad < 0 && cfg_flat[a*32 +: 32] !== model[a]) bad = a;
        if (bad < 0) check(1'b1, tag, 32'h0, 32'h0);
        else check(1'b0, tag, cfg_flat[bad*32 +: 32], model[bad]);
    endtask

    function automatic logic [31:0] pat(input int a, input int k);
        return 32'h9E3779B9 * (a + 1) + 32'h01234567 * k + 32'h80000001;
    endfunction

    // Host side of one frame; nbits may be shorter or longer than 48.
    task automatic run_frame(input logic [7:0] pad, input logic [3:0] idx, input logic rd,
                             input logic [31:0] wdata, input int nbits,
                             output logic [31:0] rdata, output int oe_err);
        logic [47:0] fr;
        fr = {pad, idx, rd, 3'b101, rd ? 32'hFFFF_FFFF : wdata};
        rdata  = '0;
        oe_err = 0;
        cs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdio_i = (i < 48) ? fr[47-i] : 1'b1;
            tick(HALF);
            sclk = 1'b1;
            if (sdio_oe !== (rd && i >= 16 && i < 48)) oe_err++;
            if (rd && i >= 16 && i < 48) rdata[47-i] = sdio_o;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF);
        if (sdio_oe !== 1'b0) oe_err++;
        cs_n = 1'b1;
        tick(HALF);
        if (sdio_oe !== 1'b0) oe_err++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          oe;
        model[0] = 32'hBEA41603; model[1] = 32'h20550288; model[2]  = 32'h0EAFA1DC;
        model[3] = 32'h698C0008; model[4] = 32'h00C00080; model[5]  = 32'h08000070;
        model[6] = 32'h08000000; model[7] = 32'h010061B2; model[8]  = 32'h01E0F401;
        model[9] = 32'h00C00002; model[10] = 32'h010061B0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: defaults
        for (int a = 0; a < NREG; a++)
            check(cfg_flat[a*32 +: 32] === model[a], "R1 default", cfg_flat[a*32 +: 32], model[a]);
        check(sdio_oe === 1'b0, "R1 oe idle", {31'b0, sdio_oe}, 32'h0);

        // R1/R3: read defaults back over the wire
        for (int a = 0; a < NREG; a++) begin
            run_frame(8'h00, 4'(a), 1'b1, 32'h0, 48, rd, oe);
            check(rd === model[a], "R3 read default", rd, model[a]);
            check(oe == 0, "R3 drive window", 32'(oe), 32'h0);
        end

        // R2/R8/R4: write every register
        for (int a = 0; a < NREG; a++) begin
            run_frame(8'h00, 4'(a), 1'b0, pat(a, 1), 48, rd, oe);
            model[a] = pat(a, 1);
            check(cfg_flat[a*32 +: 32] === model[a], "R2 write", cfg_flat[a*32 +: 32], model[a]);
            check_regs("R8 others unchanged");
            check(oe == 0, "R4 no drive on write", 32'(oe), 32'h0);
        end

        // R3: read back written values
        for (int a = NREG - 1; a >= 0; a--) begin
            run_frame(8'h00, 4'(a), 1'b1, 32'h0, 48, rd, oe);
            check(rd === model[a], "R3 read back", rd, model[a]);
            check(oe == 0, "R3 drive window", 32'(oe), 32'h0);
        end

        // R7: out-of-range index
        for (int a = NREG; a < 16; a++) begin
            run_frame(8'h00, 4'(a), 1'b0, 32'hDEADBEEF, 48, rd, oe);
            check_regs("R7 bad index write");
            run_frame(8'h00, 4'(a), 1'b1, 32'h0, 48, rd, oe);
            check(rd === 32'h0, "R7 bad index read zero", rd, 32'h0);
            check(oe == 0, "R7 bad index drive window", 32'(oe), 32'h0);
        end

        // R7: nonzero leading byte
        for (int b = 0; b < 8; b++) begin
            run_frame(8'(1 << b), 4'(b), 1'b0, 32'hCAFEF00D, 48, rd, oe);
            check_regs("R7 bad pad write");
            run_frame(8'(1 << b), 4'(b), 1'b1, 32'h0, 48, rd, oe);
            check(rd === 32'h0, "R7 bad pad read zero", rd, 32'h0);
        end

        // R6: aborted writes at phase boundaries, then a full write
        foreach (model[k]) begin end
        for (int c = 0; c < 6; c++) begin
            int cut;
            cut = (c == 0) ? 1 : (c == 1) ? 12 : (c == 2) ? 13 : (c == 3) ? 16 : (c == 4) ? 30 : 47;
            run_frame(8'h00, 4'd3, 1'b0, 32'h5A5A0000 + 32'(cut), cut, rd, oe);
            check_regs("R6 abort no change");
            run_frame(8'h00, 4'd3, 1'b0, pat(3, cut), 48, rd, oe);
            model[3] = pat(3, cut);
            check(cfg_flat[3*32 +: 32] === model[3], "R6 restart from bit one", cfg_flat[3*32 +: 32], model[3]);
        end

        // R5: activity with chip select high
        begin
            int oe_seen = 0;
            for (int i = 0; i < 60; i++) begin
                sdio_i = i[0] ^ i[2];
                tick(HALF); sclk = 1'b1;
                if (sdio_oe !== 1'b0) oe_seen++;
                tick(HALF); sclk = 1'b0;
            end
            tick(HALF);
            check_regs("R5 deselected no change");
            check(oe_seen == 0, "R5 deselected no drive", 32'(oe_seen), 32'h0);
        end

        // R9: extra clocks after the 48th
        run_frame(8'h00, 4'd7, 1'b0, 32'h13579BDF, 56, rd, oe);
        model[7] = 32'h13579BDF;
        check(cfg_flat[7*32 +: 32] === model[7], "R9 extra clocks write", cfg_flat[7*32 +: 32], model[7]);
        check(oe == 0, "R9 extra clocks write no drive", 32'(oe), 32'h0);
        run_frame(8'h00, 4'd7, 1'b1, 32'h0, 52, rd, oe);
        check(rd === model[7], "R9 extra clocks read", rd, model[7]);
        check(oe == 0, "R9 extra clocks released", 32'(oe), 32'h0);
        check_regs("R9 nothing else written");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule